// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This block settles conditional branches while they sit in the decode stage of a five-stage in-order pipeline. Fetch always runs ahead on the assumption that a branch falls through. The resolver decodes the instruction held in the fetch/decode register and builds the branch target from the sequential address and the immediate offset. It compares the two source operands with its own equality logic and then picks the next fetch address. When a branch turns out taken, the resolver redirects fetch and turns the one wrongly fetched successor into a bubble. A taken branch therefore costs a single cycle.

Source operands are read from the register file or bypassed from younger pipeline registers. These are the ALU result held in the execute/memory register and the write-back value held in the memory/write-back register. When a compared register is still being produced by an older instruction that cannot yet bypass, the resolver requests a stall. The stall holds the PC and the fetch/decode register and inserts a bubble into decode/execute. An ALU producer directly ahead costs one stall cycle. A load directly ahead costs two stall cycles, and a load two ahead costs one. All outputs are combinational functions of the current inputs. The clock and reset only time the embedded checks.

Top module: `idBranchResolver`

## Requirements
- R1: The instruction word is decoded with opcode in bits 31:26, first source in 25:21, second source in 20:16 and offset in 15:0. Opcode 6'b000100 is branch-if-equal and 6'b000101 is branch-if-not-equal. Any other opcode yields nextPc equal to idPcPlus4, with pcSel, flushIfId and stall all low.
- R2: The branch target is idPcPlus4 plus the 16-bit offset, sign-extended to 32 bits and multiplied by four. A taken branch drives nextPc to this value.
- R3: A branch-if-equal that is not stalled is taken exactly when its two resolved operands are equal. When taken, pcSel and flushIfId are high and nextPc is the target. Otherwise pcSel and flushIfId are low and nextPc is idPcPlus4.
- R4: A branch-if-not-equal that is not stalled is taken exactly when its two resolved operands differ.
- R5: If the execute-stage instruction writes (exRegWrite high) a nonzero register that the branch reads, stall is high. While stall is high, pcSel and flushIfId are low and nextPc is idPcPlus4.
- R6: A load (memIsLoad high) in the memory stage that writes a nonzero register the branch reads also raises stall. Together with R5, a load directly ahead costs two stall cycles. Its memAluResult is never used as a branch operand.
- R7: An ALU producer (memRegWrite high, memIsLoad low) in the memory stage writing a compared register causes no stall, and memAluResult replaces that operand.
- R8: A write-back producer (wbRegWrite high) writing a compared register causes no stall, and wbData replaces that operand.
- R9: When both the memory-stage ALU producer and the write-back producer match a compared register, the memory-stage value wins. When neither matches, the register file value is used.
- R10: Register index 0 never raises stall and is never replaced by a bypassed value. The register file data is used for it.
- R11: A producer whose write enable is low is ignored for both stalling and bypassing, whatever its destination and load flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the embedded checks |
| rstN | input | 1 | Active-low reset for the embedded checks |
| idInstr | input | 32 | Instruction held in the fetch/decode register |
| idPcPlus4 | input | 32 | Sequential address of that instruction plus four |
| rfData1 | input | 32 | Register file read data for the first source |
| rfData2 | input | 32 | Register file read data for the second source |
| exDest | input | 5 | Destination of the execute-stage instruction |
| exRegWrite | input | 1 | Execute-stage instruction writes a register |
| exIsLoad | input | 1 | Execute-stage instruction is a load |
| memDest | input | 5 | Destination of the memory-stage instruction |
| memRegWrite | input | 1 | Memory-stage instruction writes a register |
| memIsLoad | input | 1 | Memory-stage instruction is a load |
| memAluResult | input | 32 | ALU result held in the execute/memory register |
| wbDest | input | 5 | Destination of the write-back instruction |
| wbRegWrite | input | 1 | Write-back instruction writes a register |
| wbData | input | 32 | Value being written back |
| nextPc | output | 32 | Address for the next fetch |
| pcSel | output | 1 | High when nextPc is the branch target |
| flushIfId | output | 1 | Turns the fetched successor into a bubble |
| stall | output | 1 | Hold PC and fetch/decode, bubble into decode/execute |

## Verification
The embedded checks assume that a load flag only accompanies a set write enable. They also assume that the inputs describe one coherent set of older instructions in a given cycle. The sweep pairs every load flag with its write enable, and it drives a write enable of zero only together with a cleared load flag. Each vector is applied at the falling edge and held across the next rising edge, so the clocked checks always see settled values. Destinations are drawn from register 0, the two compared registers and an unrelated register. Operand values are drawn so that every bypass choice flips the equality result.

// File: rtl/brUnitPkg.sv
package brUnitPkg;
  // instruction field layout
  localparam int OP_HI  = 31;
  localparam int OP_LO  = 26;
  localparam int RS_HI  = 25;
  localparam int RS_LO  = 21;
  localparam int RT_HI  = 20;
  localparam int RT_LO  = 16;
  localparam int OFF_HI = 15;
  localparam int OFF_LO = 0;
  localparam int OPW    = OP_HI - OP_LO + 1;
  localparam int OFFW   = OFF_HI - OFF_LO + 1;

  localparam logic [OPW-1:0] OP_BEQ = 6'b000100;
  localparam logic [OPW-1:0] OP_BNE = 6'b000101;

  typedef enum logic [1:0] {
    FWD_RF  = 2'd0,
    FWD_MEM = 2'd1,
    FWD_WB  = 2'd2
  } fwdSel_e;

  typedef struct packed {
    fwdSel_e fwdA;
    fwdSel_e fwdB;
    logic    isBranch;
    logic    isBne;
  } brStrobes_t;
endpackage

// File: rtl/brHazardCtl.sv
module brHazardCtl
  import brUnitPkg::*;
#(
  parameter int REGW = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [OPW-1:0]   opcode,
  input  logic [REGW-1:0]  rsIdx,
  input  logic [REGW-1:0]  rtIdx,
  input  logic [REGW-1:0]  exDest,
  input  logic             exRegWrite,
  input  logic [REGW-1:0]  memDest,
  input  logic             memRegWrite,
  input  logic             memIsLoad,
  input  logic [REGW-1:0]  wbDest,
  input  logic             wbRegWrite,
  output brStrobes_t       strobes,
  output logic             stall
);
  localparam int NSRC = 2;

  logic [REGW-1:0] srcIdx [NSRC];
  logic [NSRC-1:0] opHaz;
  fwdSel_e         opFwd  [NSRC];
  logic            isBranch;

  assign srcIdx[0] = rsIdx;
  assign srcIdx[1] = rtIdx;

  // one hazard/bypass decoder per compared source
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic live, exHit, memHit, wbHit;
    assign live   = (srcIdx[i] != '0);
    assign exHit  = live && exRegWrite  && (exDest  == srcIdx[i]);
    assign memHit = live && memRegWrite && (memDest == srcIdx[i]);
    assign wbHit  = live && wbRegWrite  && (wbDest  == srcIdx[i]);
    // any producer in execute, or a load in memory, is not yet bypassable
    assign opHaz[i] = exHit || (memHit && memIsLoad);
    // youngest bypassable producer wins
    assign opFwd[i] = (memHit && !memIsLoad) ? FWD_MEM :
                      wbHit                  ? FWD_WB  : FWD_RF;
  end

  assign isBranch = (opcode == OP_BEQ) || (opcode == OP_BNE);
  assign stall    = isBranch && (|opHaz);

  always_comb begin
    strobes.fwdA     = opFwd[0];
    strobes.fwdB     = opFwd[1];
    strobes.isBranch = isBranch;
    strobes.isBne    = (opcode == OP_BNE);
  end

  // a load result still in the memory stage is never bypassed
  p_no_load_bypass_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memIsLoad |-> (strobes.fwdA != FWD_MEM && strobes.fwdB != FWD_MEM)));

  // load in memory stage writing the first source must stall a branch
  p_stall_load_mem_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((isBranch && memRegWrite && memIsLoad && rsIdx != '0 && memDest == rsIdx)
      |-> stall));

  // register zero always reads the register file
  p_zero_from_rf_r10: assert property (@(posedge clk) disable iff (!rstN)
    ((rsIdx == '0) |-> (strobes.fwdA == FWD_RF)));
endmodule

// File: rtl/brOperandPath.sv
module brOperandPath
  import brUnitPkg::*;
#(
  parameter int XLEN = 32
) (
  input  brStrobes_t       strobes,
  input  logic [XLEN-1:0]  rfData1,
  input  logic [XLEN-1:0]  rfData2,
  input  logic [XLEN-1:0]  memAluResult,
  input  logic [XLEN-1:0]  wbData,
  input  logic [XLEN-1:0]  pcPlus4,
  input  logic [OFFW-1:0]  offset,
  output logic             opEqual,
  output logic [XLEN-1:0]  brTarget
);
  localparam int NSRC = 2;
  localparam int SEXT = XLEN - OFFW - 2;

  logic [XLEN-1:0] rfVal  [NSRC];
  logic [XLEN-1:0] opVal  [NSRC];
  fwdSel_e         sel    [NSRC];
  logic [XLEN-1:0] offExt;

  assign rfVal[0] = rfData1;
  assign rfVal[1] = rfData2;
  assign sel[0]   = strobes.fwdA;
  assign sel[1]   = strobes.fwdB;

  for (genvar i = 0; i < NSRC; i++) begin : g_mux
    assign opVal[i] = (sel[i] == FWD_MEM) ? memAluResult :
                      (sel[i] == FWD_WB)  ? wbData       : rfVal[i];
  end

  // dedicated equality: xor-reduce, no subtractor
  assign opEqual  = ~|(opVal[0] ^ opVal[1]);
  assign offExt   = {{SEXT{offset[OFFW-1]}}, offset, 2'b00};
  assign brTarget = pcPlus4 + offExt;
endmodule

// File: rtl/idBranchResolver.sv
module idBranchResolver
  import brUnitPkg::*;
#(
  parameter int XLEN = 32,
  parameter int REGW = 5
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [31:0]     idInstr,
  input  logic [XLEN-1:0] idPcPlus4,
  input  logic [XLEN-1:0] rfData1,
  input  logic [XLEN-1:0] rfData2,
  input  logic [REGW-1:0] exDest,
  input  logic            exRegWrite,
  input  logic            exIsLoad,
  input  logic [REGW-1:0] memDest,
  input  logic            memRegWrite,
  input  logic            memIsLoad,
  input  logic [XLEN-1:0] memAluResult,
  input  logic [REGW-1:0] wbDest,
  input  logic            wbRegWrite,
  input  logic [XLEN-1:0] wbData,
  output logic [XLEN-1:0] nextPc,
  output logic            pcSel,
  output logic            flushIfId,
  output logic            stall
);
  brStrobes_t      ctl;
  logic            opEqual;
  logic [XLEN-1:0] brTarget;
  logic            taken;

  brHazardCtl #(.REGW(REGW)) u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .opcode     (idInstr[OP_HI:OP_LO]),
    .rsIdx      (idInstr[RS_HI:RS_LO]),
    .rtIdx      (idInstr[RT_HI:RT_LO]),
    .exDest     (exDest),
    .exRegWrite (exRegWrite),
    .memDest    (memDest),
    .memRegWrite(memRegWrite),
    .memIsLoad  (memIsLoad),
    .wbDest     (wbDest),
    .wbRegWrite (wbRegWrite),
    .strobes    (ctl),
    .stall      (stall)
  );

  brOperandPath #(.XLEN(XLEN)) u_path (
    .strobes     (ctl),
    .rfData1     (rfData1),
    .rfData2     (rfData2),
    .memAluResult(memAluResult),
    .wbData      (wbData),
    .pcPlus4     (idPcPlus4),
    .offset      (idInstr[OFF_HI:OFF_LO]),
    .opEqual     (opEqual),
    .brTarget    (brTarget)
  );

  // predict not taken; redirect and squash successor only once resolved
  assign taken     = ctl.isBranch && !stall && (opEqual ^ ctl.isBne);
  assign pcSel     = taken;
  assign flushIfId = taken;
  assign nextPc    = taken ? brTarget : idPcPlus4;

  // the load flag only travels with a write; unused by the resolver itself
  logic unusedLoadEx;
  assign unusedLoadEx = exIsLoad;

  // a stalled branch never squashes its successor
  p_no_flush_in_stall_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stall |-> !flushIfId));

  // only a branch opcode may redirect fetch
  p_redirect_branch_only_r1: assert property (@(posedge clk) disable iff (!rstN)
    (pcSel |-> (idInstr[OP_HI:OP_LO] == OP_BEQ || idInstr[OP_HI:OP_LO] == OP_BNE)));
endmodule

// File: tb/sim_idBranchResolver.sv
module sim_idBranchResolver;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rstN;
  logic [31:0] idInstr, idPcPlus4, rfData1, rfData2, memAluResult, wbData;
  logic [4:0]  exDest, memDest, wbDest;
  logic        exRegWrite, exIsLoad, memRegWrite, memIsLoad, wbRegWrite;
  logic [31:0] nextPc;
  logic        pcSel, flushIfId, stall;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  idBranchResolver u0 (.*);

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [4:0] destOf(input int k);
    case (k)
      0: return 5'd0;
      1: return 5'd3;
      2: return 5'd7;
      default: return 5'd9;
    endcase
  endfunction

  // resolve one operand from the requirements (R5..R11)
  function automatic void model(input logic [4:0] r, input logic [31:0] rfv,
                                output logic haz, output logic [31:0] v);
    haz = 1'b0;
    v   = rfv;
    if (r != 5'd0) begin
      if (exRegWrite && exDest == r) haz = 1'b1;
      if (memRegWrite && memDest == r && memIsLoad) haz = 1'b1;
      if (memRegWrite && memDest == r && !memIsLoad) v = memAluResult;
      else if (wbRegWrite && wbDest == r) v = wbData;
    end
  endfunction

  task automatic checkAll(input string ctxt);
    logic [5:0]  op;
    logic        isBr, hA, hB, expStall, expTaken;
    logic [31:0] a, b, tgt, expPc;
    string       tag;
    op   = idInstr[31:26];
    isBr = (op == 6'b000100) || (op == 6'b000101);
    model(idInstr[25:21], rfData1, hA, a);
    model(idInstr[20:16], rfData2, hB, b);
    tgt      = idPcPlus4 + ({{16{idInstr[15]}}, idInstr[15:0]} << 2);
    expStall = isBr && (hA || hB);
    expTaken = isBr && !expStall && ((a == b) ^ (op == 6'b000101));
    expPc    = expTaken ? tgt : idPcPlus4;
    if (!isBr) tag = "R1";
    else if (expStall) tag = (memIsLoad || exIsLoad) ? "R6" : "R5";
    else if (expTaken) tag = (op == 6'b000101) ? "R4" : "R3";
    else tag = "R7/R8/R9";
    tag = {tag, " ", ctxt};
    check(tag, "stall", {31'd0, stall}, {31'd0, expStall});
    check(tag, "pcSel", {31'd0, pcSel}, {31'd0, expTaken});
    check(tag, "flushIfId", {31'd0, flushIfId}, {31'd0, expTaken});
    check(tag, "nextPc", nextPc, expPc);
  endtask

  task automatic idle();
    idInstr = 32'd0; idPcPlus4 = 32'h100; rfData1 = 0; rfData2 = 0;
    memAluResult = 0; wbData = 0; exDest = 0; memDest = 0; wbDest = 0;
    exRegWrite = 0; exIsLoad = 0; memRegWrite = 0; memIsLoad = 0; wbRegWrite = 0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual running expected finished");
    finishRun();
  end

  initial begin
    int vec = 0;
    rstN = 1'b0;
    idle();
    repeat (3) @(negedge clk);
    #1 check("R1 reset", "stall", {31'd0, stall}, 32'd0);
    check("R1 reset", "nextPc", nextPc, 32'h100);
    @(negedge clk);
    rstN = 1'b1;

    // R2: most negative and most positive offsets, taken beq
    @(negedge clk);
    idle();
    idInstr = {6'b000100, 5'd3, 5'd7, 16'h8000}; idPcPlus4 = 32'h0002_0000;
    #1 check("R2 min offset", "nextPc", nextPc, 32'h0002_0000 - 32'h0002_0000);
    @(negedge clk);
    idInstr = {6'b000100, 5'd3, 5'd7, 16'h7FFF};
    #1 check("R2 max offset", "nextPc", nextPc, 32'h0002_0000 + 32'h0001_FFFC);
    @(negedge clk);
    idInstr = {6'b000100, 5'd3, 5'd7, 16'hFFFF};
    #1 check("R2 minus one", "nextPc", nextPc, 32'h0001_FFFC);

    // sweep: opcode, first source (3 or R10 zero), producers in each stage
    // with write enable low (R11), ALU or load kinds, destinations in
    // {0,3,7,9}, and operand values so bypass choice (R8, R9) flips equality
    for (int op = 0; op < 3; op++)
      for (int rsSel = 0; rsSel < 2; rsSel++)
        for (int exK = 0; exK < 3; exK++)
          for (int exD = 0; exD < 4; exD++)
            for (int mK = 0; mK < 3; mK++)
              for (int mD = 0; mD < 4; mD++)
                for (int wK = 0; wK < 2; wK++)
                  for (int wD = 0; wD < 4; wD++)
                    for (int vals = 0; vals < 8; vals++) begin
                      logic [5:0] opc;
                      @(negedge clk);
                      opc = (op == 0) ? 6'b000100 : (op == 1) ? 6'b000101 : 6'b100011;
                      idInstr = {opc, (rsSel == 0) ? 5'd3 : 5'd0, 5'd7,
                                 16'(vec * 977 + 16'h1234)};
                      idPcPlus4    = 32'h0040_0000 + 32'(vec) * 4;
                      rfData1      = 32'd5;
                      rfData2      = vals[0] ? 32'd5 : 32'd6;
                      memAluResult = vals[1] ? 32'd5 : 32'd6;
                      wbData       = vals[2] ? 32'd5 : 32'd6;
                      exDest       = destOf(exD);
                      exRegWrite   = (exK != 0);
                      exIsLoad     = (exK == 2);
                      memDest      = destOf(mD);
                      memRegWrite  = (mK != 0);
                      memIsLoad    = (mK == 2);
                      wbDest       = destOf(wD);
                      wbRegWrite   = (wK != 0);
                      #1 checkAll("sweep");
                      vec++;
                    end
    @(negedge clk);
    finishRun();
  end
endmodule